// File: doc/BRIEF.md
# Split-Field Pixel Clock Divider

This block makes a panel pixel clock from a reference clock. The divide ratio comes from a ten-bit divisor. The divisor is stored as two five-bit pieces that sit at opposite ends of a 32-bit timing word. The block takes that word in, rebuilds the divisor from the two pieces, adds two to it, and produces a divided clock. Alongside the clock it produces a single-cycle enable pulse in the reference domain, so that logic running on the reference clock can act once per pixel. A separate bypass bit in the same word forwards the reference clock unchanged, and setting that bit is the only way to get divide-by-one.

A small state machine controls the divided clock. It has four states:

- ST_WAKE is held during reset.
- ST_PASS is used while bypass is set.
- ST_LOW counts the low phase.
- ST_HIGH counts the high phase.

The transitions are:

- wake_to_low: the first clock after reset, where the ratio is captured.
- low_to_high: the end of the low phase. This is the rising edge, and the ratio is captured again here.
- high_to_low: the end of the high phase.
- any_to_pass: bypass is seen set.
- pass_to_low: bypass is seen clear, and the ratio is captured.

Because the ratio is captured only on entry to a period, a divisor written in the middle of a period never cuts a phase short.

Top module: `pcd_pixclk_div`

## Requirements
- R1: While word bit 26 (bypass) is 1, pclk_o equals clk_ref_i, pce_o is constantly 1, and the divisor bits have no effect.
- R2: While bypass is 0, each pclk_o period lasts N reference cycles, where N = divisor + 2.
- R3: The divisor is word[31:27]*32 + word[4:0]. Word bits 25:5 have no effect.
- R4: N saturates at 1023, so divisor values 1021, 1022 and 1023 all give a period of 1023 cycles.
- R5: In each period, pclk_o is high for ceil(N/2) reference cycles and low for floor(N/2). Odd ratios therefore have the high phase one cycle longer.
- R6: A new divisor takes effect only at the next rising edge of pclk_o. The period in progress completes with the old high and low lengths.
- R7: During reset, pclk_o and pce_o are 0. After release, pclk_o stays low for floor(N/2) reference cycles and then rises on the next edge.
- R8: pce_o pulses once per divided period, in the reference cycle immediately before pclk_o rises.
- R9: When bypass clears, pclk_o stays low for floor(N/2) reference cycles before its first rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| timing_word_i | input | 32 | Timing word holding the bypass bit and both divisor pieces |
| pclk_o | output | 1 | Pixel clock (divided, or the reference clock in bypass) |
| pce_o | output | 1 | Pixel-clock-enable pulse in the reference domain |

## Verification
The ratio is swept over every divisor from 0 to 46, which covers both odd and even ratios. This sweep distinguishes an off-by-one in the plus-two offset from a wrong duty split. Divisors with only the high piece set, and with both pieces set, show whether the high piece is shifted to bit 5 of the value. Junk written to bits 25:5 shows that the middle of the word is masked. The top three divisors expose a missing saturation. The remaining patterns each check one edge case: a divisor changed in the middle of the high phase, release from reset, and entry into and exit from bypass. Each of these separates capture at the rising edge from capture at any other moment.

// File: rtl/pcd_pkg.sv
package pcd_pkg;
    typedef enum logic [1:0] {
        ST_WAKE = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2,
        ST_PASS = 2'd3
    } pcd_state_e;
endpackage

// File: rtl/pcd_field_unpack.sv
module pcd_field_unpack #(
    parameter int WORD_W  = 32,
    parameter int LO_LSB  = 0,
    parameter int LO_W    = 5,
    parameter int HI_LSB  = 27,
    parameter int HI_W    = 5,
    parameter int BYP_BIT = 26,
    localparam int DIV_W  = LO_W + HI_W
) (
    input  logic [WORD_W-1:0] word_i,
    output logic              bypass_o,
    output logic [DIV_W-1:0]  ratio_o
);
    localparam logic [DIV_W:0] MAX_RATIO = (DIV_W+1)'((1 << DIV_W) - 1);

    logic [DIV_W-1:0] divisor;
    logic [DIV_W:0]   sum;

    always_comb begin
        // high piece lands directly above the low piece
        divisor  = {word_i[HI_LSB +: HI_W], word_i[LO_LSB +: LO_W]};
        bypass_o = word_i[BYP_BIT];
        sum      = {1'b0, divisor} + (DIV_W+1)'(2);
        if (sum > MAX_RATIO) ratio_o = MAX_RATIO[DIV_W-1:0];
        else                 ratio_o = sum[DIV_W-1:0];
    end
endmodule

// File: rtl/pcd_phase_fsm.sv
module pcd_phase_fsm
    import pcd_pkg::*;
#(
    parameter int RAT_W = 10
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             bypass_i,
    input  logic [RAT_W-1:0] ratio_i,
    output logic             hi_o,
    output logic             pce_o
);
    localparam logic [RAT_W:0] MAX_RATIO = (RAT_W+1)'((1 << RAT_W) - 1);

    pcd_state_e       state_q, state_d;
    logic [RAT_W-1:0] cnt_q, cnt_d;
    logic [RAT_W-1:0] ratio_q, ratio_d;
    logic [RAT_W:0]   hi_len, lo_len;
    logic             lo_done, hi_done;

    always_comb begin
        hi_len  = ({1'b0, ratio_q} + (RAT_W+1)'(1)) >> 1;
        lo_len  = {1'b0, ratio_q} >> 1;
        lo_done = ({1'b0, cnt_q} == lo_len - (RAT_W+1)'(1));
        hi_done = ({1'b0, cnt_q} == hi_len - (RAT_W+1)'(1));
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        ratio_d = ratio_q;
        if (bypass_i) begin
            state_d = ST_PASS;                 // any_to_pass
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                ST_WAKE, ST_PASS: begin        // wake_to_low / pass_to_low
                    state_d = ST_LOW;
                    cnt_d   = '0;
                    ratio_d = ratio_i;
                end
                ST_LOW: begin
                    if (lo_done) begin         // low_to_high
                        state_d = ST_HIGH;
                        cnt_d   = '0;
                        ratio_d = ratio_i;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                ST_HIGH: begin
                    if (hi_done) begin         // high_to_low
                        state_d = ST_LOW;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_WAKE;
            cnt_q   <= '0;
            ratio_q <= RAT_W'(2);
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            ratio_q <= ratio_d;
        end
    end

    // outputs
    always_comb begin
        hi_o  = (state_q == ST_HIGH);
        pce_o = (state_q == ST_LOW) && lo_done;
    end

    p_hi_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_HIGH) |-> ({1'b0, cnt_q} < hi_len));
    p_lo_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_LOW) |-> ({1'b0, cnt_q} < lo_len));
    p_ratio_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (($past(state_q) == state_q) && (state_q != ST_PASS) && (state_q != ST_WAKE))
        |-> $stable(ratio_q));
    p_ratio_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_LOW || state_q == ST_HIGH)
        |-> (ratio_q >= RAT_W'(2) && {1'b0, ratio_q} <= MAX_RATIO));
    p_wake_once_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_WAKE) |=> (state_q != ST_WAKE));
endmodule

// File: rtl/pcd_pixclk_div.sv
module pcd_pixclk_div #(
    parameter int WORD_W  = 32,
    parameter int LO_LSB  = 0,
    parameter int LO_W    = 5,
    parameter int HI_LSB  = 27,
    parameter int HI_W    = 5,
    parameter int BYP_BIT = 26
) (
    input  logic              clk_ref_i,
    input  logic              rst_ni,
    input  logic [WORD_W-1:0] timing_word_i,
    output logic              pclk_o,
    output logic              pce_o
);
    localparam int RAT_W = LO_W + HI_W;

    logic             bypass;
    logic [RAT_W-1:0] ratio;
    logic             div_hi, div_pce;

    pcd_field_unpack #(
        .WORD_W(WORD_W), .LO_LSB(LO_LSB), .LO_W(LO_W),
        .HI_LSB(HI_LSB), .HI_W(HI_W), .BYP_BIT(BYP_BIT)
    ) u_unpack (
        .word_i  (timing_word_i),
        .bypass_o(bypass),
        .ratio_o (ratio)
    );

    pcd_phase_fsm #(.RAT_W(RAT_W)) u_fsm (
        .clk_i   (clk_ref_i),
        .rst_ni  (rst_ni),
        .bypass_i(bypass),
        .ratio_i (ratio),
        .hi_o    (div_hi),
        .pce_o   (div_pce)
    );

    always_comb begin
        pclk_o = bypass ? clk_ref_i : div_hi;
        pce_o  = bypass ? 1'b1 : div_pce;
    end

    p_bypass_pce_r1: assert property (@(posedge clk_ref_i) disable iff (!rst_ni)
        bypass |-> pce_o);
    p_pce_rise_r8: assert property (@(posedge clk_ref_i) disable iff (!rst_ni)
        (div_pce && !bypass) |=> (bypass || div_hi));
endmodule

// File: tb/sim_pcd_pixclk_div.sv
module sim_pcd_pixclk_div;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] word = 32'h0;
    logic        pclk, pce;
    logic        cur, curpce, lastpce;
    int          n_chk = 0, n_bad = 0, cyc = 0;

    always #2 clk = ~clk;

    pcd_pixclk_div u0 (
        .clk_ref_i    (clk),
        .rst_ni       (rst_n),
        .timing_word_i(word),
        .pclk_o       (pclk),
        .pce_o        (pce)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    function automatic logic [31:0] mk(input int dv, input bit byp, input bit junk);
        logic [31:0] w = 32'h0;
        w[4:0]   = dv[4:0];
        w[31:27] = dv[9:5];
        w[26]    = byp;
        if (junk) w[25:5] = 21'h1F_FFFF;
        return w;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic samp();
        @(negedge clk); #1;
        lastpce = curpce;
        cur     = pclk;
        curpce  = pce;
    endtask

    task automatic wait_rise();
        logic prev;
        prev = cur;
        samp();
        while (!(cur && !prev)) begin prev = cur; samp(); end
    endtask

    // starts on first high sample; ends on next period's first high sample
    task automatic meas(input int chg_at, input logic [31:0] w2,
                        output int h, output int l, output int pcs, output int pce_last);
        h = 0; l = 0; pcs = 0;
        while (cur) begin
            h++;
            if (h == chg_at) word = w2;
            samp();
        end
        while (!cur) begin
            l++;
            if (curpce) pcs++;
            samp();
        end
        pce_last = lastpce;
    endtask

    task automatic run_ratio(input int dv, input bit junk, input string req);
        int n, h, l, pcs, pl;
        n = dv + 2;
        if (n > 1023) n = 1023;
        word = mk(dv, 1'b0, junk);
        wait_rise();
        meas(0, 32'h0, h, l, pcs, pl);
        check({req, " period"}, h + l, n);
        check({req, " high"}, h, (n + 1) / 2);
        check({req, " low"}, l, n / 2);
        check("R8 pce count", pcs, 1);
        check("R8 pce before rise", pl, 1);
    endtask

    initial begin
        int h, l, pcs, pl, lows;
        cur = 0; curpce = 0; lastpce = 0;
        word = mk(8, 1'b0, 1'b0);              // N=10
        repeat (3) samp();
        check("R7 pclk in reset", cur, 0);
        check("R7 pce in reset", curpce, 0);
        rst_n = 1'b1;
        lows = 0;
        samp();
        while (!cur && lows < 2000) begin lows++; samp(); end
        check("R7 low after release", lows, 5);
        meas(0, 32'h0, h, l, pcs, pl);
        check("R7 first high", h, 5);

        for (int dv = 0; dv <= 46; dv++) run_ratio(dv, 1'b0, "R2 R5");
        run_ratio(32, 1'b0, "R3 hi only");
        run_ratio(45, 1'b0, "R3 both pieces");
        run_ratio(992, 1'b0, "R3 hi max");
        run_ratio(9, 1'b1, "R3 junk ignored");
        run_ratio(1021, 1'b0, "R4 sat");
        run_ratio(1022, 1'b0, "R4 sat");
        run_ratio(1023, 1'b0, "R4 sat");

        // R6: change mid-high
        word = mk(6, 1'b0, 1'b0);              // N=8
        wait_rise();
        meas(0, 32'h0, h, l, pcs, pl);         // settle on N=8
        meas(2, mk(1, 1'b0, 1'b0), h, l, pcs, pl);
        check("R6 old high kept", h, 4);
        check("R6 old low kept", l, 4);
        meas(0, 32'h0, h, l, pcs, pl);
        check("R6 new high", h, 2);
        check("R6 new low", l, 1);

        // R1: bypass
        word = mk(5, 1'b1, 1'b0);
        for (int i = 0; i < 8; i++) begin
            samp();
            check("R1 pclk low half", cur, 0);
            check("R1 pce", curpce, 1);
            @(posedge clk); #1;
            check("R1 pclk high half", pclk, 1);
        end
        word = mk(700, 1'b1, 1'b1);
        samp();
        check("R1 fields ignored pce", curpce, 1);
        @(posedge clk); #1;
        check("R1 fields ignored pclk", pclk, 1);

        // R9: leave bypass, N=7
        samp();
        word = mk(5, 1'b0, 1'b0);
        lows = 0;
        samp();
        while (!cur && lows < 2000) begin lows++; samp(); end
        check("R9 low after bypass", lows, 3);
        meas(0, 32'h0, h, l, pcs, pl);
        check("R9 first high", h, 4);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule